// File: doc/BRIEF.md
# Dual Interval Timer

This block holds two independent 16-bit interval timers behind a small word-wide register port. A bus master reads and writes registers with a request, a write enable and a byte address, and gets a ready pulse one cycle later. Both channels run from the block clock. Each channel divides that clock by its own power-of-two prescaler and counts the divided ticks up to a programmed limit.

When a channel reaches its limit it raises a sticky flag. In periodic mode it then starts over. In single-shot mode it stops and turns its own run bit off. Each channel drives its own interrupt line, which is qualified by a per-channel enable. A typical use pairs one channel as a free-running time base with the other as a programmable event source.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset every register of both channels reads 0, `ready` is low and both `irq` bits are low.
- R2: Channel c (0 or 1) occupies byte addresses 0x80·(c+1) upward. Its registers sit at these offsets: +0x0 setup, +0x4 flag, +0x8 limit, +0xC live count. The setup register has interrupt enable in bit 8, run in bit 5, single-shot in bit 4 and the divider code in bits 3:0. All its other bits read 0. The limit register reads back all 16 written bits.
- R3: A request sampled at a clock edge produces `ready` high for the cycle after that edge, with the read data valid in that same cycle. A write takes effect at the sampling edge. `ready` is low in every cycle that does not follow a request.
- R4: Reads of any other address return 0. Writes to other addresses change nothing, and writes to the live-count register are ignored.
- R5: Divider code n from 0 to 8 yields one count tick every 2^n clock cycles, counted from the edge that sets the run bit. Codes 9 to 15 behave like code 8.
- R6: The live count is 0 when the run bit is set and rises by 1 on each tick. A tick that finds the count equal to the limit returns it to 0 and counts as a terminal event, so one period spans limit+1 ticks.
- R7: With single-shot clear, the channel keeps running across terminal events, so after t ticks the count reads t mod (limit+1).
- R8: With single-shot set, the first terminal event leaves the count at 0 and clears the run bit, which then reads 0.
- R9: Flag bit 0 is set by a terminal event and stays set until a write with bit 0 high clears it. A write with bit 0 low leaves it set.
- R10: `irq[c]` is high exactly when channel c's flag and its interrupt enable are both 1.
- R11: Clearing the run bit stops the channel and returns its count and divider phase to 0. Setting it again restarts counting from 0 with a fresh divider phase.
- R12: The two channels keep separate limits, divider codes and modes, and run concurrently without affecting each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the functional clock of both timers |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Register access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 10 | Byte address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid while `ready` is high |
| ready | output | 1 | Access completed, one cycle after `req` |
| irq | output | 2 | Per-channel interrupt line |

## Verification
A setup write that sets the run bit at edge E gives the count after edge E+k as (k >> code) ticks. A read sampled at edge E+k+1 returns that value, and `irq` sampled just after edge E+k reflects it. The bench drives every access at a falling edge so that each access consumes exactly one rising edge. It counts idle edges between the start and each read, derives k for each result from that count, and samples `rdata`, `ready` and `irq` at the falling edge after the completing edge. A stop is followed by one idle edge before the count is read, because the count clears on the edge after the one that saw the run bit low.

// File: rtl/ivt_pkg.sv
// Shared constants and types for the dual interval timer.
// Assumes a 16-bit data path and a 0x80-byte register window per channel.
package ivt_pkg;
    localparam int STRIDE_LSB = 7;   // channel window is 2^7 bytes
    localparam int CODE_W     = 4;   // divider code width
    localparam int MAX_CODE   = 8;   // largest effective divider exponent
    localparam int BIT_IE     = 8;
    localparam int BIT_RUN    = 5;
    localparam int BIT_SHOT   = 4;

    typedef enum logic [1:0] {
        RSEL_SETUP = 2'd0,
        RSEL_FLAG  = 2'd1,
        RSEL_LIMIT = 2'd2,
        RSEL_COUNT = 2'd3
    } rsel_e;

    typedef struct packed {
        logic              ie;
        logic              run;
        logic              shot;
        logic [CODE_W-1:0] code;
    } setup_t;
endpackage

// File: rtl/ivt_prescaler.sv
// Power-of-two clock divider for one channel.
// Emits a one-cycle tick every 2^code cycles while run is high; codes above
// MAX_CODE saturate. Phase returns to 0 whenever run is low.
module ivt_prescaler #(
    parameter int CODE_W   = 4,
    parameter int MAX_CODE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int PRE_W = MAX_CODE;
    localparam logic [CODE_W-1:0] CODE_CAP = CODE_W'(MAX_CODE);

    logic [PRE_W-1:0]  phase_q;
    logic [CODE_W-1:0] eff_code;
    logic [PRE_W:0]    span;

    assign eff_code = (code > CODE_CAP) ? CODE_CAP : code;
    assign span     = (PRE_W+1)'(1) << eff_code;
    assign tick     = run && (({1'b0, phase_q} + (PRE_W+1)'(1)) >= span);

    // Advance the divider phase, wrapping on each tick and clearing when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!run || tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + PRE_W'(1);
        end
    end
endmodule

// File: rtl/ivt_channel.sv
// One timer channel: setup, flag, limit and live-count state.
// Assumes CNT_W >= 9 so every setup field fits the data word. A terminal
// event takes priority over a same-cycle flag clear, so no event is lost.
module ivt_channel
    import ivt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_setup,
    input  logic             wr_flag,
    input  logic             wr_limit,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] setup_rd,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] limit,
    output logic             flag,
    output logic             running,
    output logic             irq
);
    setup_t           setup_q;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] limit_q;
    logic             flag_q;
    logic             tick;
    logic             term;

    ivt_prescaler #(
        .CODE_W  (CODE_W),
        .MAX_CODE(MAX_CODE)
    ) u_psc (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (setup_q.run),
        .code (setup_q.code),
        .tick (tick)
    );

    assign term = tick && (count_q == limit_q);

    // Setup register: software write, or hardware stop after a single shot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup_q <= '0;
        end else if (wr_setup) begin
            setup_q.ie   <= wdata[BIT_IE];
            setup_q.run  <= wdata[BIT_RUN];
            setup_q.shot <= wdata[BIT_SHOT];
            setup_q.code <= wdata[CODE_W-1:0];
        end else if (term && setup_q.shot) begin
            setup_q.run  <= 1'b0;
        end
    end

    // Live counter: held at 0 while stopped, wraps to 0 at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !setup_q.run) begin
            count_q <= '0;
        end else if (term) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    // Limit register: plain software-written storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q <= '0;
        end else if (wr_limit) begin
            limit_q <= wdata;
        end
    end

    // Sticky flag: set by a terminal event, cleared by writing 1 to bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (term) begin
            flag_q <= 1'b1;
        end else if (wr_flag && wdata[0]) begin
            flag_q <= 1'b0;
        end
    end

    // Assemble the setup readback; unused bits read 0.
    always_comb begin
        setup_rd                = '0;
        setup_rd[BIT_IE]        = setup_q.ie;
        setup_rd[BIT_RUN]       = setup_q.run;
        setup_rd[BIT_SHOT]      = setup_q.shot;
        setup_rd[CODE_W-1:0]    = setup_q.code;
    end

    assign count   = count_q;
    assign limit   = limit_q;
    assign flag    = flag_q;
    assign running = setup_q.run;
    assign irq     = flag_q && setup_q.ie;
endmodule

// File: rtl/dual_interval_timer.sv
// Top of the multi-channel interval timer: address decode, channel array,
// registered read data and ready. Assumes NCH channels fit the address
// space (NCH < 2^(ADDR_W-7)) and that req is a single-cycle strobe per access.
module dual_interval_timer
    import ivt_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              ready,
    output logic [NCH-1:0]    irq
);
    localparam int BLK_W = ADDR_W - STRIDE_LSB;

    logic [BLK_W-1:0]          blk;
    logic                      off_ok;
    rsel_e                     rsel;
    logic [NCH-1:0][CNT_W-1:0] ch_setup;
    logic [NCH-1:0][CNT_W-1:0] ch_count;
    logic [NCH-1:0][CNT_W-1:0] ch_limit;
    logic [NCH-1:0]            ch_flag;
    logic [NCH-1:0]            ch_run;
    logic [CNT_W-1:0]          rd_next;
    logic [CNT_W-1:0]          rdata_q;
    logic                      ready_q;

    assign blk    = addr[ADDR_W-1:STRIDE_LSB];
    assign off_ok = (addr[1:0] == 2'b00) && (addr[STRIDE_LSB-1:4] == '0);
    assign rsel   = rsel_e'(addr[3:2]);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic wsel;
        assign wsel = req && we && off_ok && (blk == BLK_W'(c + 1));

        ivt_channel #(
            .CNT_W(CNT_W)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_setup(wsel && (rsel == RSEL_SETUP)),
            .wr_flag (wsel && (rsel == RSEL_FLAG)),
            .wr_limit(wsel && (rsel == RSEL_LIMIT)),
            .wdata   (wdata),
            .setup_rd(ch_setup[c]),
            .count   (ch_count[c]),
            .limit   (ch_limit[c]),
            .flag    (ch_flag[c]),
            .running (ch_run[c]),
            .irq     (irq[c])
        );
    end

    // Select the addressed register; unmapped addresses yield 0.
    always_comb begin
        rd_next = '0;
        for (int c = 0; c < NCH; c++) begin
            if (off_ok && (blk == BLK_W'(c + 1))) begin
                unique case (rsel)
                    RSEL_SETUP: rd_next = ch_setup[c];
                    RSEL_FLAG:  rd_next = CNT_W'(ch_flag[c]);
                    RSEL_LIMIT: rd_next = ch_limit[c];
                    RSEL_COUNT: rd_next = ch_count[c];
                endcase
            end
        end
    end

    // Register the response one cycle after each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
            rdata_q <= '0;
        end else begin
            ready_q <= req;
            rdata_q <= (req && !we) ? rd_next : '0;
        end
    end

    assign rdata = rdata_q;
    assign ready = ready_q;
endmodule

// File: rtl/ivt_checker.sv
// Property checker for dual_interval_timer, attached by bind below.
// Decodes the address on its own to predict unmapped reads and flag clears.
module ivt_checker #(
    parameter int NCH    = 2,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 10
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      req,
    input logic                      we,
    input logic [ADDR_W-1:0]         addr,
    input logic                      wbit0,
    input logic [CNT_W-1:0]          rdata,
    input logic                      ready,
    input logic [NCH-1:0]            irq,
    input logic [NCH-1:0][CNT_W-1:0] ch_count,
    input logic [NCH-1:0]            ch_run,
    input logic [NCH-1:0]            ch_flag
);
    localparam int BLK_W = ADDR_W - 7;

    logic [BLK_W-1:0] blk;
    logic             mapped;

    assign blk    = addr[ADDR_W-1:7];
    assign mapped = (addr[1:0] == 2'b00) && (addr[6:4] == 3'b000)
                 && (int'(blk) >= 1) && (int'(blk) <= NCH);

    AST_READY_NEXT: assert property (@(posedge clk) disable iff (!rst_n) req |=> ready); // R3
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !req |=> !ready); // R3
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (req && !we && !mapped) |=> (rdata == '0)); // R4

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        logic clr;
        assign clr = req && we && mapped && (blk == BLK_W'(c + 1))
                  && (addr[3:2] == 2'd1) && wbit0;

        AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) (ch_count[c] != $past(ch_count[c])) |-> ((ch_count[c] == $past(ch_count[c]) + CNT_W'(1)) || (ch_count[c] == '0))); // R6
        AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) !ch_run[c] |=> (ch_count[c] == '0)); // R11
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (ch_flag[c] && !clr) |=> ch_flag[c]); // R9
        AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) irq[c] |-> ch_flag[c]); // R10
    end
endmodule

bind dual_interval_timer ivt_checker #(
    .NCH   (NCH),
    .CNT_W (CNT_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .we      (we),
    .addr    (addr),
    .wbit0   (wdata[0]),
    .rdata   (rdata),
    .ready   (ready),
    .irq     (irq),
    .ch_count(ch_count),
    .ch_run  (ch_run),
    .ch_flag (ch_flag)
);

// File: tb/sim_dual_interval_timer.sv
// Self-checking bench: directed corners plus seeded random channel runs.
module sim_dual_interval_timer;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [9:0]  addr = '0;
    logic [15:0] wdata = '0;
    wire  [15:0] rdata;
    wire         ready;
    wire  [1:0]  irq;

    int n_chk  = 0;
    int n_fail = 0;

    dual_interval_timer u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ready(ready), .irq(irq)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] base(input int c);
        return 10'((c + 1) * 128);
    endfunction

    function automatic int ticks(input int k, input int code);
        int e;
        e = (code > 8) ? 8 : code;
        return k >> e;
    endfunction

    function automatic bit evt(input int k, input int code, input int lim);
        return ticks(k, code) >= lim + 1;
    endfunction

    function automatic logic [15:0] exp_count(input int k, input int code, input int lim, input bit shot);
        int t;
        t = ticks(k, code);
        if (shot && t >= lim + 1) return 16'd0;
        return 16'(t % (lim + 1));
    endfunction

    function automatic logic [15:0] setup_word(input bit ie, input bit run, input bit shot, input int code);
        return 16'((int'(ie) << 8) | (int'(run) << 5) | (int'(shot) << 4) | (code & 15));
    endfunction

    // Each access starts at a falling edge and consumes one rising edge.
    task automatic bus_write(input logic [9:0] a, input logic [15:0] d);
        req = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic bus_read(input logic [9:0] a, output logic [15:0] d);
        req = 1'b1; we = 1'b0; addr = a;
        @(posedge clk);
        @(negedge clk);
        check("R3 ready", 16'(ready), 16'd1);
        d = rdata;
        req = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Program a channel, let it run w idle edges, then check count, flag, irq, setup.
    task automatic trial(input int c, input int lim, input int code, input bit shot, input bit ie, input int w);
        logic [15:0] d;
        string tag;
        tag = shot ? "R8" : "R7";
        bus_write(base(c) + 10'h0, 16'h0);
        bus_write(base(c) + 10'h4, 16'h1);
        bus_write(base(c) + 10'h8, 16'(lim));
        bus_write(base(c) + 10'h0, setup_word(ie, 1'b1, shot, code));
        idle(w);
        bus_read(base(c) + 10'hC, d);
        check($sformatf("R6 %s R5 count ch%0d", tag, c), d, exp_count(w, code, lim, shot));
        bus_read(base(c) + 10'h4, d);
        check("R9 flag", d, 16'(evt(w + 1, code, lim)));
        check("R10 irq", 16'(irq[c]), 16'(ie && evt(w + 2, code, lim)));
        bus_read(base(c) + 10'h0, d);
        check({tag, " setup"}, d, setup_word(ie, !(shot && evt(w + 2, code, lim)), shot, code));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [15:0] d;
        void'($urandom(32'd20240611));

        // R1: reset state
        repeat (4) @(negedge clk);
        check("R1 ready", 16'(ready), 16'd0);
        check("R1 irq", 16'(irq), 16'd0);
        rst_n = 1'b1;
        idle(1);
        check("R3 ready idle", 16'(ready), 16'd0);
        for (int c = 0; c < 2; c++) begin
            for (int r = 0; r < 4; r++) begin
                bus_read(base(c) + 10'(r * 4), d);
                check("R1 register", d, 16'h0);
            end
        end

        // R2: field layout and limit readback (code 15 stored as written)
        bus_write(base(0), 16'hFFDF);
        bus_read(base(0), d);
        check("R2 setup fields", d, 16'h011F);
        bus_write(base(0), 16'h0);
        bus_write(base(1) + 10'h8, 16'hBEEF);
        bus_read(base(1) + 10'h8, d);
        check("R2 limit", d, 16'hBEEF);

        // R4: unmapped and read-only accesses
        bus_write(base(0) + 10'hC, 16'h1234);
        bus_read(base(0) + 10'hC, d);
        check("R4 count write ignored", d, 16'h0);
        bus_write(10'h000, 16'hFFFF);
        bus_write(10'h090, 16'hFFFF);
        bus_write(10'h18A, 16'hFFFF);
        bus_write(10'h200, 16'hFFFF);
        bus_read(base(0), d);
        check("R4 ch0 setup untouched", d, 16'h0);
        bus_read(base(0) + 10'h8, d);
        check("R4 ch0 limit untouched", d, 16'h0);
        bus_read(base(1) + 10'h8, d);
        check("R4 ch1 limit untouched", d, 16'hBEEF);
        check("R4 irq untouched", 16'(irq), 16'd0);
        bus_read(10'h000, d);  check("R4 read 0x000", d, 16'h0);
        bus_read(10'h090, d);  check("R4 read 0x090", d, 16'h0);
        bus_read(10'h18A, d);  check("R4 read 0x18A", d, 16'h0);
        bus_read(10'h200, d);  check("R4 read 0x200", d, 16'h0);
        bus_read(10'h3FC, d);  check("R4 read 0x3FC", d, 16'h0);

        // R5: large and saturated divider codes
        trial(0, 3, 8, 1'b0, 1'b0, 600);
        trial(1, 3, 9, 1'b0, 1'b0, 600);
        trial(0, 0, 15, 1'b0, 1'b1, 300);

        // R9 / R10: writing 0 keeps the flag, writing 1 clears it
        trial(1, 2, 0, 1'b1, 1'b1, 10);
        bus_write(base(1), setup_word(1'b1, 1'b0, 1'b0, 0));
        check("R10 irq with flag", 16'(irq[1]), 16'd1);
        bus_write(base(1) + 10'h4, 16'hFFFE);
        bus_read(base(1) + 10'h4, d);
        check("R9 write 0 keeps flag", d, 16'h1);
        bus_write(base(1) + 10'h4, 16'h0001);
        bus_read(base(1) + 10'h4, d);
        check("R9 write 1 clears flag", d, 16'h0);
        check("R10 irq after clear", 16'(irq[1]), 16'd0);

        // R11: stop clears count, restart begins a fresh divider phase
        bus_write(base(0) + 10'h8, 16'd100);
        bus_write(base(0), setup_word(1'b0, 1'b1, 1'b0, 2));
        idle(9);
        bus_write(base(0), setup_word(1'b0, 1'b0, 1'b0, 2));
        idle(1);
        bus_read(base(0) + 10'hC, d);
        check("R11 stopped count", d, 16'h0);
        bus_write(base(0), setup_word(1'b0, 1'b1, 1'b0, 2));
        idle(5);
        bus_read(base(0) + 10'hC, d);
        check("R11 restart count", d, 16'(ticks(5, 2)));

        // R12: both channels concurrently with different settings
        bus_write(base(0), 16'h0);
        bus_write(base(1), 16'h0);
        bus_write(base(0) + 10'h4, 16'h1);
        bus_write(base(1) + 10'h4, 16'h1);
        bus_write(base(0) + 10'h8, 16'd9);
        bus_write(base(1) + 10'h8, 16'd4);
        bus_write(base(0), setup_word(1'b0, 1'b1, 1'b0, 0));
        bus_write(base(1), setup_word(1'b1, 1'b1, 1'b1, 2));
        idle(30);
        bus_read(base(0) + 10'hC, d);
        check("R12 ch0 count", d, exp_count(31, 0, 9, 1'b0));
        bus_read(base(1) + 10'hC, d);
        check("R12 ch1 count", d, exp_count(31, 2, 4, 1'b1));
        check("R12 ch1 irq", 16'(irq[1]), 16'd1);
        check("R12 ch0 irq", 16'(irq[0]), 16'd0);

        // Seeded random runs covering R5 to R10
        for (int i = 0; i < 40; i++) begin
            int c, lim, code, w;
            bit shot, ie;
            c    = int'($urandom_range(1, 0));
            lim  = int'($urandom_range(15, 0));
            code = int'($urandom_range(3, 0));
            shot = 1'($urandom_range(1, 0));
            ie   = 1'($urandom_range(1, 0));
            w    = int'($urandom_range(150, 0));
            trial(c, lim, code, shot, ie, w);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule